// File: doc/BRIEF.md
# SD Data Block Count Sequencer

This block follows the progress of multi-block data transfers for an SD/MMC host controller. Software programs a block length and a block count. There are two register views, one for the narrow (16-bit) data path and one for the wide (32-bit) data path, and each view has its own length and count registers. Two mode bits, one in a data control register and one in a wide control register, decide which view is active.

When a data command is launched, the block arms itself. The datapath reports each completed block on `blk_done_i`. For each completed block, the sequencer emits a block pulse and advances its count. On the final block it either requests an automatic stop command (CMD12) and ends the transfer, or it keeps accepting blocks with no end.

The two views update their counts in different ways:
- **Wide view:** the count register itself decrements after each block. It holds at 1 on the last block and never reaches 0.
- **Narrow view:** the count register is left untouched. A hidden copy, loaded at launch, tracks progress instead.

Top module: `sd_blk_top`

## Requirements
- R1: After reset, both lengths and both counts read 0, the data control register reads 1010h, wide mode is off, and `active_o`, `blk_pulse_o`, `xfer_done_o` and `stop_req_o` are 0.
- R2: Register select codes on `wr_sel_i` are: 0 data control, 1 wide control, 2 stop control, 3 narrow length, 4 wide length, 5 narrow count, 6 wide count. The data control register reads back 1010h, with bit 1 equal to the last written bit 1. `wide_o` is 1 only when bit 1 of the data control register and bit 1 of the wide control register are both 1.
- R3: Each length register keeps bits 9..0 of the written value, and bits 15..10 read 0. The narrow length clips any kept value above 200h to 200h. The wide length keeps values up to 3FFh. `blk_len_o` shows the wide length when `wide_o` is 1 and the narrow length otherwise.
- R4: `start_i` sets `active_o` on the next cycle, latches the mode and loads the hidden count from the narrow count register. A `blk_done_i` in the same cycle as `start_i` is ignored.
- R5: A `blk_done_i` while `active_o` is 1 gives a single-cycle `blk_pulse_o` in the following cycle. A `blk_done_i` while `active_o` is 0 gives no pulse and changes no count.
- R6: In a wide transfer, each accepted block decrements the wide count while it is above 1. A block seen at count 1 or 0 is the last block, and the count stays unchanged. A register write to the wide count takes priority over a decrement in the same cycle.
- R7: In a narrow transfer, the narrow count register never changes because of blocks. The hidden count decrements per block while above 1, and the block seen at hidden count 1 or 0 is the last block.
- R8: If stop control bit 8 is 1 on the last block, `xfer_done_o` and `stop_req_o` pulse for one cycle together with `blk_pulse_o`, and `active_o` drops in that same cycle.
- R9: If stop control bit 8 is 0 on the last block, `active_o` stays 1, no stop is requested, and every further block is again treated as the last block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 3 | Register select code |
| wr_data_i | input | 16 | Register write data |
| start_i | input | 1 | Data command launch |
| blk_done_i | input | 1 | Datapath finished one block |
| dctl_o | output | 16 | Data control readback |
| len16_o | output | 16 | Narrow block length |
| len32_o | output | 16 | Wide block length |
| cnt16_o | output | 16 | Narrow block count |
| cnt32_o | output | 16 | Wide block count |
| wide_o | output | 1 | Wide mode selected |
| blk_len_o | output | 16 | Length of the active view |
| active_o | output | 1 | Transfer in progress |
| blk_pulse_o | output | 1 | One block completed |
| xfer_done_o | output | 1 | Final block completed with auto-stop |
| stop_req_o | output | 1 | Request to issue CMD12 |

## Verification
The bench targets the following corner cases:
- **Last-block hold.** A wide count of 1 or 0 must hold rather than wrap. A design that decremented it unconditionally would show FFFFh or 0, and the end of the transfer would be lost.
- **Narrow count untouched.** A narrow transfer must leave its count register alone. A design that shared the wide decrement would alter the visible count.
- **Narrow clip boundary.** Lengths 1FFh, 200h, 201h and 3FFh are written in both views. A missing clip would show up as 201h or 3FFh in the narrow view.
- **Ignored and colliding blocks.** Blocks arriving while inactive, and a block arriving in the same cycle as a launch, must be dropped. A design that accepted them would pulse or count too early.
- **Endless mode.** A transfer without auto-stop must stay active past its last block and keep pulsing with no stop request.

// File: rtl/sd_blk_pkg.sv
package sd_blk_pkg;
  localparam int SEL_W = 3;
  typedef enum logic [SEL_W-1:0] {
    SEL_DCTL  = 3'd0,
    SEL_WCTL  = 3'd1,
    SEL_STOP  = 3'd2,
    SEL_LEN16 = 3'd3,
    SEL_LEN32 = 3'd4,
    SEL_CNT16 = 3'd5,
    SEL_CNT32 = 3'd6
  } reg_sel_e;
  localparam int MODE_BIT = 1;
  localparam int STOP_BIT = 8;
  localparam logic [15:0] DCTL_FIXED = 16'h1010;
endpackage

// File: rtl/sd_blk_regs.sv
module sd_blk_regs
  import sd_blk_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LEN_W     = 10,
  parameter int CNT_W     = 16,
  parameter int LEN16_MAX = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [SEL_W-1:0] wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             dec32_i,
  output logic [DW-1:0]    dctl_o,
  output logic [DW-1:0]    len16_o,
  output logic [DW-1:0]    len32_o,
  output logic [CNT_W-1:0] cnt16_o,
  output logic [CNT_W-1:0] cnt32_o,
  output logic             wide_o,
  output logic             stop_en_o
);
  localparam logic [LEN_W-1:0] LEN16_CLIP = LEN_W'(LEN16_MAX);

  reg_sel_e         sel;
  logic             dmode_q, wmode_q, stop_q;
  logic [LEN_W-1:0] len16_q, len32_q, wr_len, wr_len16;
  logic [CNT_W-1:0] cnt16_q, cnt32_q;

  assign sel      = reg_sel_e'(wr_sel_i);
  assign wr_len   = wr_data_i[LEN_W-1:0];
  assign wr_len16 = (wr_len > LEN16_CLIP) ? LEN16_CLIP : wr_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dmode_q <= 1'b0;
      wmode_q <= 1'b0;
      stop_q  <= 1'b0;
      len16_q <= '0;
      len32_q <= '0;
      cnt16_q <= '0;
      cnt32_q <= '0;
    end else begin
      if (wr_en_i) begin
        unique case (sel)
          SEL_DCTL:  dmode_q <= wr_data_i[MODE_BIT];
          SEL_WCTL:  wmode_q <= wr_data_i[MODE_BIT];
          SEL_STOP:  stop_q  <= wr_data_i[STOP_BIT];
          SEL_LEN16: len16_q <= wr_len16;
          SEL_LEN32: len32_q <= wr_len;
          SEL_CNT16: cnt16_q <= wr_data_i[CNT_W-1:0];
          SEL_CNT32: cnt32_q <= wr_data_i[CNT_W-1:0];
          default: ;
        endcase
      end
      // software write wins over block decrement
      if (dec32_i && !(wr_en_i && sel == SEL_CNT32)) cnt32_q <= cnt32_q - 1'b1;
    end
  end

  always_comb begin
    dctl_o           = DCTL_FIXED;
    dctl_o[MODE_BIT] = dmode_q;
  end
  assign len16_o   = DW'(len16_q);
  assign len32_o   = DW'(len32_q);
  assign cnt16_o   = cnt16_q;
  assign cnt32_o   = cnt32_q;
  assign wide_o    = dmode_q & wmode_q;
  assign stop_en_o = stop_q;
endmodule

// File: rtl/sd_blk_seq.sv
module sd_blk_seq #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             blk_done_i,
  input  logic             wide_i,
  input  logic             stop_en_i,
  input  logic [CNT_W-1:0] cnt16_i,
  input  logic [CNT_W-1:0] cnt32_i,
  output logic             dec32_o,
  output logic             active_o,
  output logic             blk_pulse_o,
  output logic             xfer_done_o,
  output logic             stop_req_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic             act_q, wide_q, accept, last, finish;
  logic [CNT_W-1:0] hid_q;

  assign accept  = blk_done_i & act_q & ~start_i;
  assign last    = wide_q ? (cnt32_i <= ONE) : (hid_q <= ONE);
  assign finish  = accept & last & stop_en_i;
  assign dec32_o = accept & wide_q & ~last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q       <= 1'b0;
      wide_q      <= 1'b0;
      hid_q       <= '0;
      blk_pulse_o <= 1'b0;
      xfer_done_o <= 1'b0;
      stop_req_o  <= 1'b0;
    end else begin
      blk_pulse_o <= accept;
      xfer_done_o <= finish;
      stop_req_o  <= finish;
      if (start_i) begin
        act_q  <= 1'b1;
        wide_q <= wide_i;
        hid_q  <= cnt16_i;
      end else if (accept) begin
        if (!wide_q && !last) hid_q <= hid_q - 1'b1;
        if (finish) act_q <= 1'b0;
      end
    end
  end

  assign active_o = act_q;
endmodule

// File: rtl/sd_blk_top.sv
module sd_blk_top
  import sd_blk_pkg::*;
#(
  parameter int DW        = 16,
  parameter int LEN_W     = 10,
  parameter int CNT_W     = 16,
  parameter int LEN16_MAX = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_sel_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             start_i,
  input  logic             blk_done_i,
  output logic [DW-1:0]    dctl_o,
  output logic [DW-1:0]    len16_o,
  output logic [DW-1:0]    len32_o,
  output logic [CNT_W-1:0] cnt16_o,
  output logic [CNT_W-1:0] cnt32_o,
  output logic             wide_o,
  output logic [DW-1:0]    blk_len_o,
  output logic             active_o,
  output logic             blk_pulse_o,
  output logic             xfer_done_o,
  output logic             stop_req_o
);
  logic dec32, stop_en;

  sd_blk_regs #(
    .DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W), .LEN16_MAX(LEN16_MAX)
  ) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .dec32_i   (dec32),
    .dctl_o    (dctl_o),
    .len16_o   (len16_o),
    .len32_o   (len32_o),
    .cnt16_o   (cnt16_o),
    .cnt32_o   (cnt32_o),
    .wide_o    (wide_o),
    .stop_en_o (stop_en)
  );

  sd_blk_seq #(.CNT_W(CNT_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .blk_done_i  (blk_done_i),
    .wide_i      (wide_o),
    .stop_en_i   (stop_en),
    .cnt16_i     (cnt16_o),
    .cnt32_i     (cnt32_o),
    .dec32_o     (dec32),
    .active_o    (active_o),
    .blk_pulse_o (blk_pulse_o),
    .xfer_done_o (xfer_done_o),
    .stop_req_o  (stop_req_o)
  );

  assign blk_len_o = wide_o ? len32_o : len16_o;
endmodule

// File: rtl/sd_blk_chk.sv
module sd_blk_chk #(
  parameter int DW    = 16,
  parameter int CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [2:0]       wr_sel_i,
  input logic             start_i,
  input logic             blk_done_i,
  input logic [DW-1:0]    dctl_o,
  input logic [DW-1:0]    len16_o,
  input logic [DW-1:0]    len32_o,
  input logic [CNT_W-1:0] cnt16_o,
  input logic [CNT_W-1:0] cnt32_o,
  input logic             active_o,
  input logic             blk_pulse_o,
  input logic             xfer_done_o,
  input logic             stop_req_o
);
  a_r2_fixed_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dctl_o[12] && dctl_o[4]);

  a_r3_len_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (len16_o <= DW'(16'h200)) && (len32_o[DW-1:10] == '0));

  a_r5_pulse_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && blk_done_i && !start_i |=> blk_pulse_o);

  a_r5_no_idle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o |=> !blk_pulse_o);

  a_r6_hold_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt32_o == CNT_W'(1)) && !(wr_en_i && wr_sel_i == 3'd6) |=> cnt32_o == CNT_W'(1));

  a_r7_cnt16_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_sel_i == 3'd5) |=> $stable(cnt16_o));

  a_r8_done_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done_o |-> blk_pulse_o && stop_req_o && !active_o);
endmodule

bind sd_blk_top sd_blk_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_sel_i    (wr_sel_i),
  .start_i     (start_i),
  .blk_done_i  (blk_done_i),
  .dctl_o      (dctl_o),
  .len16_o     (len16_o),
  .len32_o     (len32_o),
  .cnt16_o     (cnt16_o),
  .cnt32_o     (cnt32_o),
  .active_o    (active_o),
  .blk_pulse_o (blk_pulse_o),
  .xfer_done_o (xfer_done_o),
  .stop_req_o  (stop_req_o)
);

// File: tb/tb_sd_blk_top.sv
module tb_sd_blk_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic        start = 1'b0;
  logic        blk_done = 1'b0;
  logic [15:0] dctl, len16, len32, cnt16, cnt32, blk_len;
  logic        wide, active, blk_pulse, xfer_done, stop_req;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_blk_top dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .start_i(start), .blk_done_i(blk_done),
    .dctl_o(dctl), .len16_o(len16), .len32_o(len32), .cnt16_o(cnt16),
    .cnt32_o(cnt32), .wide_o(wide), .blk_len_o(blk_len), .active_o(active),
    .blk_pulse_o(blk_pulse), .xfer_done_o(xfer_done), .stop_req_o(stop_req)
  );

  // behavioural reference model
  int m_dm, m_wm, m_stop, m_len16, m_len32, m_cnt16, m_cnt32;
  int m_act, m_wx, m_hid, m_pulse, m_done;

  task automatic model_reset();
    m_dm = 0; m_wm = 0; m_stop = 0; m_len16 = 0; m_len32 = 0;
    m_cnt16 = 0; m_cnt32 = 0; m_act = 0; m_wx = 0; m_hid = 0;
    m_pulse = 0; m_done = 0;
  endtask

  initial model_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) model_reset();
    else begin
      int n32, last, v;
      n32 = m_cnt32;
      m_pulse = 0;
      m_done  = 0;
      if (start) begin
        m_act = 1; m_wx = m_dm & m_wm; m_hid = m_cnt16;
      end else if (blk_done && m_act == 1) begin
        m_pulse = 1;
        last = m_wx ? (m_cnt32 <= 1) : (m_hid <= 1);
        if (!last) begin
          if (m_wx) n32 = m_cnt32 - 1; else m_hid = m_hid - 1;
        end
        if (last && m_stop) begin m_done = 1; m_act = 0; end
      end
      if (wr_en) begin
        v = wr_data & 16'h3FF;
        case (wr_sel)
          3'd0: m_dm = wr_data[1];
          3'd1: m_wm = wr_data[1];
          3'd2: m_stop = wr_data[8];
          3'd3: m_len16 = (v > 'h200) ? 'h200 : v;
          3'd4: m_len32 = v;
          3'd5: m_cnt16 = wr_data;
          3'd6: n32 = wr_data;
          default: ;
        endcase
      end
      m_cnt32 = n32;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // compare every cycle away from the active edge
  always @(negedge clk) if (rst_n) begin
    int ew;
    ew = m_dm & m_wm;
    chk("R2 dctl", dctl, 'h1010 | (m_dm << 1));
    chk("R2 wide", wide, ew);
    chk("R3 len16", len16, m_len16);
    chk("R3 len32", len32, m_len32);
    chk("R3 blk_len", blk_len, ew ? m_len32 : m_len16);
    chk("R7 cnt16", cnt16, m_cnt16);
    chk("R6 cnt32", cnt32, m_cnt32);
    chk("R4 active", active, m_act);
    chk("R5 blk_pulse", blk_pulse, m_pulse);
    chk("R8 xfer_done", xfer_done, m_done);
    chk("R8 stop_req", stop_req, m_done);
  end

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 0; start = 0; blk_done = 0;
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wr_en = 1; wr_sel = 3'(sel); wr_data = 16'(data); start = 0; blk_done = 0;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic launch();
    @(negedge clk);
    wr_en = 0; start = 1; blk_done = 0;
    @(negedge clk);
    start = 0;
  endtask

  task automatic blk();
    @(negedge clk);
    wr_en = 0; start = 0; blk_done = 1;
    @(negedge clk);
    blk_done = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 dctl reset", dctl, 'h1010);
    chk("R1 cnt32 reset", cnt32, 0);
    chk("R1 cnt16 reset", cnt16, 0);
    chk("R1 len16 reset", len16, 0);
    chk("R1 active reset", active, 0);
    chk("R1 pulse reset", blk_pulse | xfer_done | stop_req, 0);

    // R2 mode bits
    wr(0, 'h0000); wr(0, 'h0002); wr(1, 'h0002);
    chk("R2 wide on", wide, 1);
    // R3 length boundaries
    wr(3, 'h01FF); wr(3, 'h0200); wr(3, 'h0201);
    chk("R3 clip 201", len16, 'h200);
    wr(3, 'hFFFF); wr(4, 'hFFFF);
    chk("R3 wide 3FF", len32, 'h3FF);
    wr(4, 'h0201);
    // R5 ignored while idle
    blk(); blk();
    chk("R5 idle ignore", cnt32, 0);

    // wide with auto-stop, count 3
    wr(2, 'h0100); wr(6, 3); launch(); blk(); idle(2); blk(); blk();
    chk("R8 ended", active, 0);
    chk("R6 stuck at 1", cnt32, 1);

    // narrow with auto-stop, count 2
    wr(0, 0); wr(5, 2); launch(); blk(); blk();
    chk("R7 cnt16 kept", cnt16, 2);

    // R9 no auto-stop, endless
    wr(0, 2); wr(2, 0); wr(6, 2); launch();
    repeat (4) blk();
    chk("R9 still active", active, 1);
    chk("R9 count at 1", cnt32, 1);

    // count 0, start colliding with block (R4)
    wr(2, 'h0100); wr(6, 0);
    @(negedge clk); start = 1; blk_done = 1;
    @(negedge clk); start = 0; blk_done = 0;
    chk("R4 collide active", active, 1);
    blk();
    chk("R6 zero is last", active, 0);

    // mixed stimulus
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      start    = ($urandom_range(15) == 0);
      blk_done = ($urandom_range(2) == 0);
      wr_en    = ($urandom_range(7) == 0);
      wr_sel   = 3'($urandom_range(6));
      wr_data  = 16'($urandom_range(5) == 0 ? $urandom_range(3) : $urandom);
    end
    idle(3);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule